// File: doc/BRIEF.md
# Serial Peripheral Bus Master with Selectable Clock Modes

This block runs single-word, full-duplex transfers on a four-wire serial peripheral bus as the bus master. A one-cycle start strobe latches a parallel transmit word, the clock polarity, the clock phase and a half-period divider. The block then pulls the active-low select line low and toggles the serial clock for exactly two edges per bit. One shift register carries the word out most-significant bit first and takes in the slave's bits at its least-significant end. After the last edge the clock rests at its idle level for one more half-period, the select line is released, and the received word is presented together with a one-cycle completion pulse.

All four polarity and phase combinations are supported. The polarity sets the level at which the clock rests. The phase decides whether the slave's bits are sampled on the leading edges or the trailing edges of each clock pulse. Outgoing bits change on the other kind of edge. A strobe that arrives during a transfer is dropped. Mode, divider and data inputs are read only at the moment a transfer is accepted.

Top module: `spi_xfer_master`

## Requirements
- R1: Synchronous reset leaves the select line high, busy low, the completion pulse low and the received word at zero.
- R2: While no transfer is running, the serial clock follows the polarity input with one cycle of delay (polarity 0 gives a low idle level, polarity 1 a high one).
- R3: A start strobe seen while idle drives the select line low and busy high on the next cycle, and MOSI then already shows bit W-1 of the transmit word.
- R4: One clock half-period lasts `div` system clocks, and a value of 0 acts as 1. The first clock edge comes one half-period after the select line falls, exactly 2*W edges follow, and the select line rises one half-period after the last edge. A transfer therefore occupies (2*W+1)*div cycles.
- R5: With phase 0 the slave's bits are sampled on the odd-numbered (leading) edges, and with phase 1 on the even-numbered (trailing) edges. A leading edge rises when polarity is 0 and falls when polarity is 1.
- R6: The slave, sampling MOSI on the sampling edges, receives the transmit word most-significant bit first. MOSI changes only on the edges that do not sample.
- R7: MISO is sampled on each sampling edge and enters at bit 0 of the shift register, so after a transfer the received word equals the word the slave sent, with its first bit at position W-1.
- R8: The completion pulse is high for exactly one cycle, in the same cycle that the select line rises and busy falls. The received word holds its value until the next completion.
- R9: A start strobe that arrives while busy has no effect: the timing and data of the running transfer are unchanged, and no new transfer follows it.
- R10: Changes to polarity, phase, divider or transmit word during a transfer do not alter that transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to begin a transfer |
| tx_word_i | input | W | Word to send |
| cpol_i | input | 1 | Clock idle level |
| cpha_i | input | 1 | Sampling phase: 0 leading, 1 trailing |
| div_i | input | DIV_W | Half-period length in system clocks |
| miso_i | input | 1 | Serial data from the slave |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the slave |
| ss_n_o | output | 1 | Active-low slave select |
| rx_word_o | output | W | Word received in the last transfer |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Transfer in progress |

## Verification
The bench builds the block with W=8 and DIV_W=4. The narrow divider makes both its top value of 15 and the value 0, which behaves as 1, easy to reach, and it keeps the longest transfer at 255 cycles. Many randomly chosen transfers therefore fit in the run, and each of the four modes is seen with several divider values. A behavioural slave in the bench checks the direction of each edge, the exact cycle at which each edge falls, and the data exchanged in both directions.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

    typedef enum logic [1:0] {
        XS_IDLE = 2'd0,
        XS_RUN  = 2'd1,
        XS_HOLD = 2'd2
    } xfer_state_e;

    typedef struct packed {
        logic pol;
        logic pha;
    } bus_mode_t;

    // The next edge samples when it is leading and the phase is 0,
    // or trailing and the phase is 1.
    function automatic logic edge_samples(input logic next_is_leading, input logic pha);
        return next_is_leading ^ pha;
    endfunction

endpackage

// File: rtl/spi_xfer_timer.sv
module spi_xfer_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic [DIV_W-1:0] half_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q;

    assign tick_o = run_i && (cnt_q == half_i - DIV_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !run_i || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        run_i |-> (cnt_q < half_i));

endmodule

// File: rtl/spi_xfer_shifter.sv
module spi_xfer_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] tx_i,
    input  logic         sample_i,
    input  logic         launch_i,
    input  logic         finish_i,
    input  logic         miso_i,
    output logic         mosi_o,
    output logic [W-1:0] rx_o
);
    logic [W-1:0] sh_q;
    logic         mosi_q;
    logic [W-1:0] rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            mosi_q <= 1'b0;
            rx_q   <= '0;
        end else begin
            if (load_i) begin
                sh_q   <= tx_i;
                mosi_q <= tx_i[W-1];
            end else begin
                if (sample_i) begin
                    sh_q <= {sh_q[W-2:0], miso_i};
                end
                if (launch_i) begin
                    mosi_q <= sh_q[W-1];
                end
            end
            if (finish_i) begin
                rx_q <= sh_q;
            end
        end
    end

    assign mosi_o = mosi_q;
    assign rx_o   = rx_q;

    // R3
    mosi_load_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (mosi_o == $past(tx_i[W-1])));

    // R8
    rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !finish_i |=> $stable(rx_o));

    // R5
    no_mixed_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !(sample_i && launch_i));

endmodule

// File: rtl/spi_xfer_ctrl.sv
module spi_xfer_ctrl
    import spi_xfer_pkg::*;
#(
    parameter int W     = 8,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             cpol_i,
    input  logic             cpha_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             tick_i,
    output logic [DIV_W-1:0] half_o,
    output logic             load_o,
    output logic             sample_o,
    output logic             launch_o,
    output logic             finish_o,
    output logic             done_o,
    output logic             busy_o,
    output logic             sck_o,
    output logic             ss_n_o
);
    localparam int              EW        = $clog2(2 * W + 1);
    localparam logic [EW-1:0]   LAST_EDGE = EW'(2 * W - 1);
    localparam logic [EW-1:0]   ALL_EDGES = EW'(2 * W);

    xfer_state_e      state_q;
    bus_mode_t        mode_q;
    logic [DIV_W-1:0] half_q;
    logic [EW-1:0]    edge_q;
    logic             sck_q;
    logic             ss_n_q;
    logic             done_q;

    logic edge_now;
    logic next_leading;
    logic last_edge;

    assign edge_now     = (state_q == XS_RUN) && tick_i;
    assign next_leading = ~edge_q[0];
    assign last_edge    = (edge_q == LAST_EDGE);

    assign load_o   = (state_q == XS_IDLE) && start_i;
    assign sample_o = edge_now && edge_samples(next_leading, mode_q.pha);
    assign launch_o = edge_now && !edge_samples(next_leading, mode_q.pha) && !last_edge;
    assign finish_o = (state_q == XS_HOLD) && tick_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= XS_IDLE;
            mode_q  <= '0;
            half_q  <= DIV_W'(1);
            edge_q  <= '0;
            sck_q   <= 1'b0;
            ss_n_q  <= 1'b1;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                XS_IDLE: begin
                    sck_q <= cpol_i;
                    if (start_i) begin
                        mode_q.pol <= cpol_i;
                        mode_q.pha <= cpha_i;
                        half_q     <= (div_i == '0) ? DIV_W'(1) : div_i;
                        edge_q     <= '0;
                        ss_n_q     <= 1'b0;
                        state_q    <= XS_RUN;
                    end
                end
                XS_RUN: begin
                    if (tick_i) begin
                        sck_q  <= ~sck_q;
                        edge_q <= edge_q + EW'(1);
                        if (last_edge) begin
                            state_q <= XS_HOLD;
                        end
                    end
                end
                XS_HOLD: begin
                    if (tick_i) begin
                        ss_n_q  <= 1'b1;
                        done_q  <= 1'b1;
                        state_q <= XS_IDLE;
                    end
                end
                default: state_q <= XS_IDLE;
            endcase
        end
    end

    assign half_o = half_q;
    assign done_o = done_q;
    assign busy_o = (state_q != XS_IDLE);
    assign sck_o  = sck_q;
    assign ss_n_o = ss_n_q;

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R8
    done_release_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($rose(ss_n_o) && !busy_o));

    // R9
    select_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ss_n_o) |-> $past(!busy_o));

    // R4
    sck_gated_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o) && !$stable(sck_o)) |-> (!ss_n_o && $past(!ss_n_o)));

    // R4
    edge_bound_chk: assert property (@(posedge clk) disable iff (rst)
        edge_q <= ALL_EDGES);

    // R4
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == XS_HOLD) |-> (sck_o == mode_q.pol));

    // R2
    idle_level_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && $past(!busy_o) && !$past(rst)) |-> (sck_o == $past(cpol_i)));

endmodule

// File: rtl/spi_xfer_master.sv
module spi_xfer_master #(
    parameter int W     = 8,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [W-1:0]     tx_word_i,
    input  logic             cpol_i,
    input  logic             cpha_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             miso_i,
    output logic             sck_o,
    output logic             mosi_o,
    output logic             ss_n_o,
    output logic [W-1:0]     rx_word_o,
    output logic             done_o,
    output logic             busy_o
);
    logic [DIV_W-1:0] half_w;
    logic             tick_w;
    logic             load_w;
    logic             sample_w;
    logic             launch_w;
    logic             finish_w;
    logic             busy_w;

    spi_xfer_ctrl #(.W(W), .DIV_W(DIV_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .cpol_i   (cpol_i),
        .cpha_i   (cpha_i),
        .div_i    (div_i),
        .tick_i   (tick_w),
        .half_o   (half_w),
        .load_o   (load_w),
        .sample_o (sample_w),
        .launch_o (launch_w),
        .finish_o (finish_w),
        .done_o   (done_o),
        .busy_o   (busy_w),
        .sck_o    (sck_o),
        .ss_n_o   (ss_n_o)
    );

    spi_xfer_timer #(.DIV_W(DIV_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run_i  (busy_w),
        .half_i (half_w),
        .tick_o (tick_w)
    );

    spi_xfer_shifter #(.W(W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .load_i   (load_w),
        .tx_i     (tx_word_i),
        .sample_i (sample_w),
        .launch_i (launch_w),
        .finish_i (finish_w),
        .miso_i   (miso_i),
        .mosi_o   (mosi_o),
        .rx_o     (rx_word_o)
    );

    assign busy_o = busy_w;

endmodule

// File: tb/spi_xfer_master_bench.sv
module spi_xfer_master_bench;
    localparam int W          = 8;
    localparam int DW         = 4;
    localparam int CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [W-1:0]  tx_word_i = '0;
    logic          cpol_i = 1'b0;
    logic          cpha_i = 1'b0;
    logic [DW-1:0] div_i = DW'(1);
    logic          miso_i = 1'b0;
    logic          sck_o, mosi_o, ss_n_o, done_o, busy_o;
    logic [W-1:0]  rx_word_o;

    int checks = 0;
    int errors = 0;

    spi_xfer_master #(.W(W), .DIV_W(DW)) u_spi_xfer_master (
        .clk(clk), .rst(rst), .start_i(start_i), .tx_word_i(tx_word_i),
        .cpol_i(cpol_i), .cpha_i(cpha_i), .div_i(div_i), .miso_i(miso_i),
        .sck_o(sck_o), .mosi_o(mosi_o), .ss_n_o(ss_n_o), .rx_word_o(rx_word_o),
        .done_o(done_o), .busy_o(busy_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int eff_div(input int dv);
        return (dv == 0) ? 1 : dv;
    endfunction

    function automatic bit samples_on(input int e, input bit pha);
        return (pha == 1'b0) ? (e % 2 == 1) : (e % 2 == 0);
    endfunction

    task automatic run_xfer(input logic [W-1:0] tx, input logic [W-1:0] slv,
                            input bit pol, input bit pha, input int dv, input bit disturb);
        int d;
        int e;
        int bad_time;
        int bad_dir;
        int total;
        logic prev_sck;
        logic [W-1:0] srx;
        bit finished;
        d = eff_div(dv);
        total = (2 * W + 1) * d;
        @(negedge clk);
        tx_word_i = tx; cpol_i = pol; cpha_i = pha; div_i = DW'(dv); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        // R3: select low, busy high, first bit on MOSI
        check(ss_n_o == 1'b0 && busy_o == 1'b1, "R3 select/busy", {ss_n_o, busy_o}, 2'b01);
        check(mosi_o == tx[W-1], "R3 first bit", mosi_o, tx[W-1]);
        miso_i = slv[W-1];
        prev_sck = sck_o;
        e = 0; bad_time = 0; bad_dir = 0; srx = '0; finished = 0;
        for (int k = 1; k <= total + 2; k++) begin
            bit changed;
            bit exp_edge;
            @(negedge clk);
            changed  = (sck_o != prev_sck);
            exp_edge = (k % d == 0) && (k <= 2 * W * d);
            if (changed != exp_edge) bad_time++;
            if (changed) begin
                e++;
                if (samples_on(e, pha)) begin
                    if ((sck_o == 1'b1) != (pol == pha)) bad_dir++;
                    srx = {srx[W-2:0], mosi_o};
                end else if (pha == 1'b0) begin
                    if (e / 2 < W) miso_i = slv[W-1-(e/2)];
                end else begin
                    miso_i = slv[W-((e+1)/2)];
                end
            end
            prev_sck = sck_o;
            if (k == total) begin
                // R8 completion cycle
                check(done_o && ss_n_o && !busy_o, "R8 done/select/busy", {done_o, ss_n_o, busy_o}, 3'b110);
                // R4 idle level, edge count and timing
                check(sck_o == pol, "R4 clock rests at idle", sck_o, pol);
                check(e == 2 * W, "R4 edge count", e, 2 * W);
                check(bad_time == 0, "R4 edge timing", bad_time, 0);
                // R5 sampling edge direction
                check(bad_dir == 0, "R5 sampling edge direction", bad_dir, 0);
                // R6 slave received transmit word
                check(srx == tx, "R6 MOSI data", srx, tx);
                // R7 master received slave word
                check(rx_word_o == slv, "R7 received word", rx_word_o, slv);
                finished = 1;
                break;
            end else if (done_o || ss_n_o) begin
                check(1'b0, "R4 early end", k, total);
                finished = 1;
                break;
            end
            if (disturb) begin
                if (k == 2) begin
                    start_i = 1'b1; tx_word_i = ~tx; cpol_i = ~pol; cpha_i = ~pha;
                    div_i = DW'(dv + 3);
                end else if (k == 3) begin
                    start_i = 1'b0;
                end
            end
        end
        if (!finished) check(1'b0, "R4 transfer never ended", 0, total);
        cpol_i = pol;
        @(negedge clk);
        // R8 pulse width and held word; R9 no second transfer
        check(!done_o, "R8 single-cycle pulse", done_o, 0);
        check(!busy_o && ss_n_o, "R9 no restart", {busy_o, ss_n_o}, 2'b01);
        check(rx_word_o == slv, "R8 word held", rx_word_o, slv);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5EED_0031;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(ss_n_o && !busy_o && !done_o, "R1 reset outputs", {ss_n_o, busy_o, done_o}, 3'b100);
        check(rx_word_o == '0, "R1 reset word", rx_word_o, 0);
        // R2 idle level follows polarity
        cpol_i = 1'b1; repeat (2) @(negedge clk);
        check(sck_o == 1'b1, "R2 idle high", sck_o, 1);
        cpol_i = 1'b0; repeat (2) @(negedge clk);
        check(sck_o == 1'b0, "R2 idle low", sck_o, 0);

        // directed: all four modes, fastest divider
        for (int m = 0; m < 4; m++) begin
            run_xfer(8'hA5, 8'h3C, m[1], m[0], 1, 1'b0);
        end
        // directed: divider 0 acts as 1, top divider, flat patterns
        run_xfer(8'hFF, 8'h00, 1'b0, 1'b1, 0, 1'b0);
        run_xfer(8'h00, 8'hFF, 1'b1, 1'b0, 15, 1'b0);
        run_xfer(8'h81, 8'h7E, 1'b1, 1'b1, 2, 1'b0);
        // R9 and R10: strobe and input changes mid-transfer
        run_xfer(8'hC3, 8'h96, 1'b0, 1'b0, 3, 1'b1);
        run_xfer(8'h5A, 8'h1E, 1'b1, 1'b1, 1, 1'b1);

        for (int n = 0; n < 40; n++) begin
            logic [W-1:0] t;
            logic [W-1:0] s;
            int mode;
            int dv;
            t = W'($urandom);
            s = W'($urandom);
            mode = $urandom % 4;
            dv = $urandom % 6;
            run_xfer(t, s, mode[1], mode[0], dv, ($urandom % 4) == 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule